// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory can accept normal traffic. While reset is active, and for a stable-clock interval after reset is released, it keeps clock enable low and drives a no-operation command. It also keeps the data mask high, so the device's data pins stay high-impedance. After the interval it raises clock enable, precharges every bank, loads the supplied mode word, and issues the required auto-refresh commands. Each command is followed by the minimum gap the device needs.

All timing is given in nanoseconds or microseconds and converted to whole clock cycles from a clock-frequency parameter, with each result rounded up. An elaboration parameter selects whether the refreshes come before or after the mode-register load. When the last gap has expired the block raises a ready flag. The flag stays high until the next reset, and a memory controller can use it to take over the bus.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is low, and on every cycle before clock enable rises, `cke` is 0, the bus encodes NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `addr` and `ba` are zero, `dqm` is 1 and `init_done` is 0.
- R2: `cke` first reads 1 on exactly cycle W = STABLE_US*CLK_MHZ after reset release (cycle 0 is the cycle in which reset goes high). It then stays 1 until reset.
- R3: `dqm` is 1 on every cycle in which `init_done` is 0, and 0 once `init_done` is 1.
- R4: The first command is precharge-all ({cs_n,ras_n,cas_n,we_n} = 0010 with `addr[10]` = 1). It is issued on cycle W+1.
- R5: The mode-register load ({cs_n,ras_n,cas_n,we_n} = 0000) drives `mode_word` on `addr` with `ba` = 0, and is issued exactly once.
- R6: Exactly N_REFRESH auto-refresh commands ({cs_n,ras_n,cas_n,we_n} = 0001) are issued, and no other command codes appear.
- R7: With REF_FIRST = 1 all refreshes precede the mode-register load. With REF_FIRST = 0 all refreshes follow it.
- R8: Consecutive commands are spaced by max(2, ceil(t*CLK_MHZ/1000)) cycles, where t is the time that belongs to the earlier command: T_RP_NS after precharge, T_RFC_NS after refresh, and T_MRD_CK cycles after the mode-register load.
- R9: `init_done` rises exactly one gap (per R8) after the last command and stays 1 until reset.
- R10: Asserting reset at any point, mid-sequence or after completion, returns the outputs at once to the R1 state, and the full sequence restarts on release.
- R11: Every cycle without a command encodes NOP, with `addr` and `ba` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ADDR_W | Value loaded into the device mode register |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| dqm | output | 1 | Data mask |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
Every state decodes directly onto the pins, so a wrong state shows up at the ports in the same cycle. A miscounted stable interval moves the `cke` edge away from cycle W. A wrong transition shows a misplaced, missing or reordered command within about 35 cycles after `cke` rises. An off-by-one in a gap shifts every later command and the `init_done` edge by one cycle. The bench records the cycle and code of every command and compares them with a schedule it computes from the timing parameters, for both ordering variants and for random mode words and reset lengths.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_MHZ   = 200,
  parameter int STABLE_US = 200,
  parameter int T_RP_NS   = 18,
  parameter int T_RFC_NS  = 63,
  parameter int T_MRD_CK  = 2,
  parameter int N_REFRESH = 2,
  parameter bit REF_FIRST = 1'b1,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              dqm,
  output logic              init_done
);
  localparam int WAIT_CYC = STABLE_US * CLK_MHZ;
  localparam int RP_CYC   = (T_RP_NS * CLK_MHZ + 999) / 1000;
  localparam int RFC_CYC  = (T_RFC_NS * CLK_MHZ + 999) / 1000;
  localparam int RP_GAP   = (RP_CYC < 2 ? 2 : RP_CYC) - 1;
  localparam int RFC_GAP  = (RFC_CYC < 2 ? 2 : RFC_CYC) - 1;
  localparam int MRD_GAP  = (T_MRD_CK < 2 ? 2 : T_MRD_CK) - 1;
  localparam int CW = $clog2(WAIT_CYC + RP_CYC + RFC_CYC + T_MRD_CK + 4);
  localparam int RW = $clog2(N_REFRESH + 1);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  typedef enum logic [3:0] {
    S_WAIT, S_CKE, S_PRE, S_WRP, S_REF, S_WRFC, S_MRS, S_WMRD, S_DONE
  } st_t;

  st_t          st, nxt;
  logic [CW-1:0] cnt;
  logic [RW-1:0] nref;

  always_comb begin
    nxt = st;
    case (st)
      S_WAIT: if (cnt == CW'(WAIT_CYC - 1)) nxt = S_CKE;
      S_CKE:  nxt = S_PRE;
      S_PRE:  nxt = S_WRP;
      S_WRP:  if (cnt == CW'(RP_GAP - 1)) nxt = REF_FIRST ? S_REF : S_MRS;
      S_REF:  nxt = S_WRFC;
      S_WRFC: if (cnt == CW'(RFC_GAP - 1)) begin
                if (nref != RW'(N_REFRESH)) nxt = S_REF;
                else                        nxt = REF_FIRST ? S_MRS : S_DONE;
              end
      S_MRS:  nxt = S_WMRD;
      S_WMRD: if (cnt == CW'(MRD_GAP - 1)) nxt = REF_FIRST ? S_DONE : S_REF;
      S_DONE: nxt = S_DONE;
      default: nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cnt  <= '0;
      nref <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + 1'b1;
      if (st == S_REF) nref <= nref + 1'b1;
    end
  end

  wire is_pre = (st == S_PRE);
  wire is_ref = (st == S_REF);
  wire is_mrs = (st == S_MRS);

  assign cke       = (st != S_WAIT);
  assign cs_n      = 1'b0;
  assign ras_n     = ~(is_pre | is_ref | is_mrs);
  assign cas_n     = ~(is_ref | is_mrs);
  assign we_n      = ~(is_pre | is_mrs);
  assign addr      = is_mrs ? mode_word : (is_pre ? ALL_BANKS : '0);
  assign ba        = '0;
  assign init_done = (st == S_DONE);
  assign dqm       = ~init_done;
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int WAIT_CYC = 40000,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mode_word,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              dqm,
  input logic              init_done
);
  wire nop = !cs_n && ras_n && cas_n && we_n;
  wire pre = !cs_n && !ras_n && cas_n && !we_n;
  wire mrs = !cs_n && !ras_n && !cas_n && !we_n;

  int low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= 0;
    else if (!cke && low_cnt < WAIT_CYC + 1) low_cnt <= low_cnt + 1;
  end

  a_r1_idle_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (nop && dqm && !init_done && addr == '0 && ba == '0));
  a_r2_cke_edge_at_wait_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_cnt == WAIT_CYC));
  a_r2_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  a_r3_dqm_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    dqm == !init_done);
  a_r4_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> addr[10]);
  a_r5_mode_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mrs |-> (addr == mode_word && ba == '0));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r9_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(nop));
  a_r11_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !nop |-> cke);
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .WAIT_CYC(WAIT_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cke(cke), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
  .dqm(dqm), .init_done(init_done)
);

// File: tb/sdram_powerup_seq_bench.sv
`timescale 1ns/1ps
module sdram_powerup_seq_bench;
  localparam int CLK_MHZ = 200, STABLE_US = 200, T_RP_NS = 18, T_RFC_NS = 63;
  localparam int T_MRD_CK = 2, N_REF = 2, AW = 13, BW = 2;
  localparam int W = STABLE_US * CLK_MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic [1:0] cke, cs_n, ras_n, cas_n, we_n, dqm, done;
  logic [AW-1:0] addr [2];
  logic [BW-1:0] ba [2];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 2; g++) begin : gen_dut
    sdram_powerup_seq #(
      .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP_NS(T_RP_NS),
      .T_RFC_NS(T_RFC_NS), .T_MRD_CK(T_MRD_CK), .N_REFRESH(N_REF),
      .REF_FIRST(g == 0), .ADDR_W(AW), .BA_W(BW)
    ) u_sdram_powerup_seq (
      .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cke(cke[g]),
      .cs_n(cs_n[g]), .ras_n(ras_n[g]), .cas_n(cas_n[g]), .we_n(we_n[g]),
      .addr(addr[g]), .ba(ba[g]), .dqm(dqm[g]), .init_done(done[g])
    );
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gap_ns(int ns);
    int c = (ns * CLK_MHZ + 999) / 1000;
    return c < 2 ? 2 : c;
  endfunction

  function automatic int gap_ck(int c);
    return c < 2 ? 2 : c;
  endfunction

  // 0 NOP, 1 precharge, 2 refresh, 3 mode load, 9 illegal
  function automatic int opc(int i);
    case ({cs_n[i], ras_n[i], cas_n[i], we_n[i]})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 9;
    endcase
  endfunction

  task automatic idle_check(string req);
    for (int i = 0; i < 2; i++) begin
      chk(cke[i] == 1'b0, req, "cke in reset", cke[i], 0);
      chk(opc(i) == 0, req, "command in reset", opc(i), 0);
      chk(dqm[i] == 1'b1 && done[i] == 1'b0, req, "dqm/done in reset",
          {dqm[i], done[i]}, 2);
    end
  endtask

  int cke_rise[2], done_rise[2], ncmd[2], cke_drop[2], done_drop[2];
  int bad_dqm[2], bad_nop[2], bad_mrs[2], bad_pre[2];
  int cmd_cyc[2][8], cmd_op[2][8];

  task automatic sample(int i, int k);
    int op = opc(i);
    if (cke[i] && cke_rise[i] < 0) cke_rise[i] = k;
    if (!cke[i] && cke_rise[i] >= 0) cke_drop[i]++;
    if (op != 0) begin
      if (ncmd[i] < 8) begin
        cmd_cyc[i][ncmd[i]] = k;
        cmd_op[i][ncmd[i]] = op;
      end
      ncmd[i]++;
      if (op == 3 && (addr[i] != mode_word || ba[i] != '0)) bad_mrs[i]++;
      if (op == 1 && !addr[i][10]) bad_pre[i]++;
    end else if (addr[i] != '0 || ba[i] != '0) bad_nop[i]++;
    if (dqm[i] != !done[i]) bad_dqm[i]++;
    if (done[i] && done_rise[i] < 0) done_rise[i] = k;
    if (!done[i] && done_rise[i] >= 0) done_drop[i]++;
  endtask

  task automatic full_run(int rst_len, logic [AW-1:0] mw);
    int ecyc[8], eop[8], n, t;
    mode_word = mw;
    @(negedge clk) rst_n = 1'b0;
    #1 idle_check("R10");
    repeat (rst_len) @(negedge clk) idle_check("R1");
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      cke_rise[i] = -1; done_rise[i] = -1; ncmd[i] = 0; cke_drop[i] = 0;
      done_drop[i] = 0; bad_dqm[i] = 0; bad_nop[i] = 0; bad_mrs[i] = 0;
      bad_pre[i] = 0;
    end
    for (int k = 0; k <= W + 60; k++) begin
      if (k == 0) #1; else @(negedge clk);
      for (int i = 0; i < 2; i++) sample(i, k);
    end
    for (int i = 0; i < 2; i++) begin
      n = 0; t = W + 1;
      ecyc[n] = t; eop[n++] = 1; t += gap_ns(T_RP_NS);
      if (i == 0) begin
        for (int r = 0; r < N_REF; r++) begin ecyc[n] = t; eop[n++] = 2; t += gap_ns(T_RFC_NS); end
        ecyc[n] = t; eop[n++] = 3; t += gap_ck(T_MRD_CK);
      end else begin
        ecyc[n] = t; eop[n++] = 3; t += gap_ck(T_MRD_CK);
        for (int r = 0; r < N_REF; r++) begin ecyc[n] = t; eop[n++] = 2; t += gap_ns(T_RFC_NS); end
      end
      chk(cke_rise[i] == W, "R2", "cke rise cycle", cke_rise[i], W);
      chk(cke_drop[i] == 0, "R2", "cke low after rise", cke_drop[i], 0);
      chk(ncmd[i] == n, "R6", "command count", ncmd[i], n);
      for (int c = 0; c < n && c < 8; c++) begin
        chk(cmd_op[i][c] == eop[c], "R7", "command order", cmd_op[i][c], eop[c]);
        chk(cmd_cyc[i][c] == ecyc[c], "R8", "command cycle", cmd_cyc[i][c], ecyc[c]);
      end
      chk(cmd_cyc[i][0] == W + 1, "R4", "precharge cycle", cmd_cyc[i][0], W + 1);
      chk(bad_pre[i] == 0, "R4", "precharge without A10", bad_pre[i], 0);
      chk(bad_mrs[i] == 0, "R5", "mode load bus mismatch", bad_mrs[i], 0);
      chk(bad_nop[i] == 0, "R11", "NOP with nonzero address", bad_nop[i], 0);
      chk(bad_dqm[i] == 0, "R3", "dqm vs done", bad_dqm[i], 0);
      chk(done_rise[i] == t, "R9", "done rise cycle", done_rise[i], t);
      chk(done_drop[i] == 0, "R9", "done dropped", done_drop[i], 0);
    end
  endtask

  task automatic abort_run(int run_len);
    mode_word = AW'($urandom);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (run_len) @(negedge clk);
    rst_n = 1'b0;
    #1 idle_check("R10");
    @(negedge clk) idle_check("R10");
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #1 idle_check("R1");
    full_run(5, '1);
    abort_run(W - 2 + ($urandom % 3));
    abort_run(100 + ($urandom % 2900));
    full_run(2 + ($urandom % 8), AW'($urandom));
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_up();
  end
endmodule